// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block sits between instruction issue and architectural state in an out-of-order core. Each issued instruction takes the next slot of a circular buffer. The slot index comes back to the issuer at once and acts as the rename tag for the instruction's destination. Execution units finish in any order and post their results by tag on a completion bus. The buffer holds each speculative result in its slot and retires slots strictly in program order, one per cycle, and only once the oldest slot holds its result.

A retiring slot writes a register through the register commit port, or memory through the store commit port. A branch may retire with no other effect. If a retiring branch was mispredicted, every younger slot is discarded in the same cycle and the pointers return to their starting state. While a slot holds a finished but unretired result, a newly issuing instruction can read that result through the operand lookup port. The lookup keeps a per-register map of the newest in-flight writer.

Top module: `inorderRetireBuf`

## Requirements
- R1: After reset the buffer is empty: issueReady is 1, commitRegValid, commitStoreValid and flushOut are 0, and lookupHit is 0 for every register.
- R2: Each accepted issue (issueValid and issueReady high at a clock edge) returns on issueTag the slot it takes. Tags run 0,1,2,... and wrap from DEPTH-1 (7) back to 0.
- R3: With DEPTH (8) unretired slots, issueReady is 0 and an issue request does not allocate a slot.
- R4: Slots retire in allocation order, at most one per cycle, and only once the oldest slot has received its completion. Completions may arrive in any order.
- R5: issueKind encodes 0 = register write, 1 = store, 2 = branch, 3 = no destination. A retiring kind-0 slot drives commitRegValid with commitRegIdx = its destination and commitRegValue = its result. A retiring kind-1 slot drives commitStoreValid with commitStoreAddr = its destination field and commitStoreValue = its result. Neither port fires for any other kind.
- R6: A kind-2 slot whose completion carried cmplMispredict = 1 raises flushOut when it retires. In that cycle issueReady is 0 and an issue request is ignored. No younger slot ever retires, every register mapping is dropped, and the next accepted issue gets tag 0.
- R7: A kind-2 slot completed with cmplMispredict = 0, and a kind-3 slot, both retire with no commit port active and no flush.
- R8: lookupHit is 1 when an unretired kind-0 slot targets lookupReg. lookupTag then names the youngest such slot. lookupReady shows whether that slot has its result, and lookupValue gives the result when lookupReady is 1.
- R9: When a kind-0 slot retires, its register's mapping is dropped only if the mapping still names that slot. If a younger writer has taken the register, lookup keeps returning the younger tag.
- R10: A completion whose tag names an unallocated slot is ignored. A slot allocated later at that index still waits for its own completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| issueValid | input | 1 | Request to allocate a slot |
| issueKind | input | 2 | Instruction kind (R5 encoding) |
| issueDest | input | log2(REGS) = 5 | Destination register, or store address for kind 1 |
| issueReady | output | 1 | A slot can be taken this cycle |
| issueTag | output | log2(DEPTH) = 3 | Slot index given to the issuing instruction |
| cmplValid | input | 1 | Completion bus strobe |
| cmplTag | input | log2(DEPTH) = 3 | Slot the completion belongs to |
| cmplValue | input | DATA_W = 32 | Result value |
| cmplMispredict | input | 1 | Branch outcome was mispredicted |
| commitRegValid | output | 1 | Register write at retirement |
| commitRegIdx | output | log2(REGS) = 5 | Register being written |
| commitRegValue | output | DATA_W = 32 | Value being written |
| commitStoreValid | output | 1 | Store performed at retirement |
| commitStoreAddr | output | log2(REGS) = 5 | Store address field |
| commitStoreValue | output | DATA_W = 32 | Store data |
| flushOut | output | 1 | Mispredicted branch retiring; all slots discarded |
| lookupReg | input | log2(REGS) = 5 | Register whose in-flight producer is asked for |
| lookupHit | output | 1 | An unretired writer exists |
| lookupTag | output | log2(DEPTH) = 3 | Tag of the youngest writer |
| lookupReady | output | 1 | That writer has its result |
| lookupValue | output | DATA_W = 32 | That writer's result |

## Verification
The retirement order is tried with groups of three instructions completed in order, in reverse and in two mixed orders. Other groups mix register writes with stores, branches and no-destination slots, and one group has two writers of the same register. A wrong retirement order, a wrong port choice or a stale mapping each shows up as a mismatch against the program-order list. Directed sequences fill all eight slots to check back-pressure and tag wrap, and post a completion to an empty slot. One sequence puts a mispredicted branch ahead of finished younger work, and another moves a register's mapping to a younger writer while the older one is still waiting.

// File: rtl/retirePkg.sv
package retirePkg;

  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2,
    KIND_NOP    = 2'd3
  } instKindT;

  // strobes from the control to the datapath, one cycle's worth
  typedef struct packed {
    logic alloc;
    logic commit;
    logic flush;
  } retireStrobesT;

endpackage

// File: rtl/retireCtrl.sv
module retireCtrl
  import retirePkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       issueValid,
  input  logic                       headValid,
  input  logic                       headDone,
  input  instKindT                   headKind,
  input  logic                       headMisp,
  output retireStrobesT              strobes,
  output logic [$clog2(DEPTH)-1:0]   headIdx,
  output logic [$clog2(DEPTH)-1:0]   tailIdx,
  output logic                       issueReady
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] tailPtr;
  logic [PTR_W-1:0] count;
  logic             full;
  logic             doAlloc;
  logic             doCommit;
  logic             doFlush;

  always_comb begin
    full     = (headPtr[IDX_W] != tailPtr[IDX_W]) &&
               (headPtr[IDX_W-1:0] == tailPtr[IDX_W-1:0]);
    doCommit = headValid && headDone;
    doFlush  = doCommit && (headKind == KIND_BRANCH) && headMisp;
    doAlloc  = issueValid && !full && !doFlush;
    issueReady = !full && !doFlush;
    strobes  = '{alloc: doAlloc, commit: doCommit, flush: doFlush};
    headIdx  = headPtr[IDX_W-1:0];
    tailIdx  = tailPtr[IDX_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN || doFlush) begin
      headPtr <= '0;
      tailPtr <= '0;
      count   <= '0;
    end else begin
      if (doAlloc)  tailPtr <= tailPtr + PTR_W'(1);
      if (doCommit) headPtr <= headPtr + PTR_W'(1);
      count <= count + PTR_W'(doAlloc) - PTR_W'(doCommit);
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    count <= PTR_W'(DEPTH));

  assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rstN)
    (count == PTR_W'(DEPTH)) |-> !strobes.alloc);

  assert_ptr_count_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tailPtr - headPtr) == count);

  assert_head_steps_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.commit && !strobes.flush) |=> headPtr == $past(headPtr) + PTR_W'(1));

  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.flush |=> (count == '0) && (headPtr == tailPtr));

endmodule

// File: rtl/retireData.sv
module retireData
  import retirePkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REGS   = 32,
  parameter int DATA_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  retireStrobesT              strobes,
  input  logic [$clog2(DEPTH)-1:0]   headIdx,
  input  logic [$clog2(DEPTH)-1:0]   tailIdx,
  input  instKindT                   issueKind,
  input  logic [$clog2(REGS)-1:0]    issueDest,
  input  logic                       cmplValid,
  input  logic [$clog2(DEPTH)-1:0]   cmplTag,
  input  logic [DATA_W-1:0]          cmplValue,
  input  logic                       cmplMisp,
  input  logic [$clog2(REGS)-1:0]    lookupReg,
  output logic                       headValid,
  output logic                       headDone,
  output instKindT                   headKind,
  output logic                       headMisp,
  output logic [$clog2(REGS)-1:0]    headDest,
  output logic [DATA_W-1:0]          headValue,
  output logic                       lookupHit,
  output logic [$clog2(DEPTH)-1:0]   lookupTag,
  output logic                       lookupReady,
  output logic [DATA_W-1:0]          lookupValue
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int REG_W = $clog2(REGS);

  logic              entValid [DEPTH];
  logic              entDone  [DEPTH];
  instKindT          entKind  [DEPTH];
  logic [REG_W-1:0]  entDest  [DEPTH];
  logic [DATA_W-1:0] entValue [DEPTH];
  logic              entMisp  [DEPTH];

  logic              mapValid [REGS];
  logic [IDX_W-1:0]  mapTag   [REGS];

  // slot storage: one register group per slot
  for (genvar i = 0; i < DEPTH; i++) begin : gSlot
    logic isTail;
    logic isHead;
    logic isCmpl;
    assign isTail = strobes.alloc  && (tailIdx == IDX_W'(i));
    assign isHead = strobes.commit && (headIdx == IDX_W'(i));
    assign isCmpl = cmplValid && (cmplTag == IDX_W'(i)) && entValid[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        entValid[i] <= 1'b0;
        entDone[i]  <= 1'b0;
        entKind[i]  <= KIND_NOP;
        entDest[i]  <= '0;
        entValue[i] <= '0;
        entMisp[i]  <= 1'b0;
      end else if (strobes.flush) begin
        entValid[i] <= 1'b0;
        entDone[i]  <= 1'b0;
      end else begin
        if (isTail) begin
          entValid[i] <= 1'b1;
          entDone[i]  <= 1'b0;
          entKind[i]  <= issueKind;
          entDest[i]  <= issueDest;
          entMisp[i]  <= 1'b0;
        end else if (isHead) begin
          entValid[i] <= 1'b0;
          entDone[i]  <= 1'b0;
        end
        if (isCmpl) begin
          entDone[i]  <= 1'b1;
          entValue[i] <= cmplValue;
          entMisp[i]  <= cmplMisp;
        end
      end
    end

    assert_idle_not_done_R10: assert property (@(posedge clk) disable iff (!rstN)
      !entValid[i] |-> !entDone[i]);
  end

  // newest-writer map: one entry per architectural register
  for (genvar r = 0; r < REGS; r++) begin : gMap
    logic setMap;
    logic dropMap;
    assign setMap  = strobes.alloc && (issueKind == KIND_REG) &&
                     (issueDest == REG_W'(r));
    assign dropMap = strobes.commit && (headKind == KIND_REG) &&
                     (headDest == REG_W'(r)) && mapValid[r] &&
                     (mapTag[r] == headIdx);

    always_ff @(posedge clk) begin
      if (!rstN || strobes.flush) begin
        mapValid[r] <= 1'b0;
        mapTag[r]   <= '0;
      end else if (setMap) begin
        mapValid[r] <= 1'b1;
        mapTag[r]   <= tailIdx;
      end else if (dropMap) begin
        mapValid[r] <= 1'b0;
      end
    end

    assert_map_names_live_R9: assert property (@(posedge clk) disable iff (!rstN)
      mapValid[r] |-> entValid[mapTag[r]]);
  end

  always_comb begin
    headValid   = entValid[headIdx];
    headDone    = entDone[headIdx];
    headKind    = entKind[headIdx];
    headMisp    = entMisp[headIdx];
    headDest    = entDest[headIdx];
    headValue   = entValue[headIdx];
    lookupHit   = mapValid[lookupReg];
    lookupTag   = mapTag[lookupReg];
    lookupReady = mapValid[lookupReg] && entDone[mapTag[lookupReg]];
    lookupValue = entValue[mapTag[lookupReg]];
  end

  assert_commit_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.commit |-> entValid[headIdx] && entDone[headIdx]);

  assert_stray_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmplValid && !entValid[cmplTag]) |=> !entDone[$past(cmplTag)]);

endmodule

// File: rtl/inorderRetireBuf.sv
module inorderRetireBuf
  import retirePkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int REGS   = 32,
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      issueValid,
  input  logic [1:0]                issueKind,
  input  logic [$clog2(REGS)-1:0]   issueDest,
  output logic                      issueReady,
  output logic [$clog2(DEPTH)-1:0]  issueTag,
  input  logic                      cmplValid,
  input  logic [$clog2(DEPTH)-1:0]  cmplTag,
  input  logic [DATA_W-1:0]         cmplValue,
  input  logic                      cmplMispredict,
  output logic                      commitRegValid,
  output logic [$clog2(REGS)-1:0]   commitRegIdx,
  output logic [DATA_W-1:0]         commitRegValue,
  output logic                      commitStoreValid,
  output logic [$clog2(REGS)-1:0]   commitStoreAddr,
  output logic [DATA_W-1:0]         commitStoreValue,
  output logic                      flushOut,
  input  logic [$clog2(REGS)-1:0]   lookupReg,
  output logic                      lookupHit,
  output logic [$clog2(DEPTH)-1:0]  lookupTag,
  output logic                      lookupReady,
  output logic [DATA_W-1:0]         lookupValue
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int REG_W = $clog2(REGS);

  retireStrobesT     strobes;
  logic [IDX_W-1:0]  headIdx;
  logic [IDX_W-1:0]  tailIdx;
  logic              headValid;
  logic              headDone;
  instKindT          headKind;
  logic              headMisp;
  logic [REG_W-1:0]  headDest;
  logic [DATA_W-1:0] headValue;

  retireCtrl #(.DEPTH(DEPTH)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .headValid  (headValid),
    .headDone   (headDone),
    .headKind   (headKind),
    .headMisp   (headMisp),
    .strobes    (strobes),
    .headIdx    (headIdx),
    .tailIdx    (tailIdx),
    .issueReady (issueReady)
  );

  retireData #(.DEPTH(DEPTH), .REGS(REGS), .DATA_W(DATA_W)) data_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .headIdx     (headIdx),
    .tailIdx     (tailIdx),
    .issueKind   (instKindT'(issueKind)),
    .issueDest   (issueDest),
    .cmplValid   (cmplValid),
    .cmplTag     (cmplTag),
    .cmplValue   (cmplValue),
    .cmplMisp    (cmplMispredict),
    .lookupReg   (lookupReg),
    .headValid   (headValid),
    .headDone    (headDone),
    .headKind    (headKind),
    .headMisp    (headMisp),
    .headDest    (headDest),
    .headValue   (headValue),
    .lookupHit   (lookupHit),
    .lookupTag   (lookupTag),
    .lookupReady (lookupReady),
    .lookupValue (lookupValue)
  );

  always_comb begin
    issueTag         = tailIdx;
    commitRegValid   = strobes.commit && (headKind == KIND_REG);
    commitRegIdx     = headDest;
    commitRegValue   = headValue;
    commitStoreValid = strobes.commit && (headKind == KIND_STORE);
    commitStoreAddr  = headDest;
    commitStoreValue = headValue;
    flushOut         = strobes.flush;
  end

  assert_one_port_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({commitRegValid, commitStoreValid, flushOut}));

endmodule

// File: tb/inorderRetireBuf_tb_top.sv
`timescale 1ns/1ps
module inorderRetireBuf_tb_top;

  localparam int DEPTH  = 8;
  localparam int REGS   = 32;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic [2:0][1:0] kinds;
    logic [2:0][4:0] dests;
    logic [2:0][1:0] order;
    logic [31:0]     base;
  } vecT;

  // element [0] is the last item of each concatenation
  localparam vecT VECS [6] = '{
    '{ {2'd0,2'd0,2'd0}, {5'd3,5'd2,5'd1},   {2'd2,2'd1,2'd0}, 32'h1000 },
    '{ {2'd0,2'd0,2'd0}, {5'd6,5'd5,5'd4},   {2'd0,2'd1,2'd2}, 32'h2000 },
    '{ {2'd0,2'd1,2'd0}, {5'd8,5'd9,5'd7},   {2'd0,2'd2,2'd1}, 32'h3000 },
    '{ {2'd0,2'd1,2'd1}, {5'd10,5'd4,5'd3},  {2'd1,2'd2,2'd0}, 32'h4000 },
    '{ {2'd3,2'd0,2'd2}, {5'd0,5'd11,5'd0},  {2'd1,2'd0,2'd2}, 32'h5000 },
    '{ {2'd0,2'd0,2'd0}, {5'd13,5'd12,5'd12},{2'd2,2'd0,2'd1}, 32'h6000 }
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        issueValid;
  logic [1:0]  issueKind;
  logic [4:0]  issueDest;
  logic        issueReady;
  logic [2:0]  issueTag;
  logic        cmplValid;
  logic [2:0]  cmplTag;
  logic [31:0] cmplValue;
  logic        cmplMispredict;
  logic        commitRegValid;
  logic [4:0]  commitRegIdx;
  logic [31:0] commitRegValue;
  logic        commitStoreValid;
  logic [4:0]  commitStoreAddr;
  logic [31:0] commitStoreValue;
  logic        flushOut;
  logic [4:0]  lookupReg;
  logic        lookupHit;
  logic [2:0]  lookupTag;
  logic        lookupReady;
  logic [31:0] lookupValue;

  always #2.5 clk = ~clk;

  inorderRetireBuf #(.DEPTH(DEPTH), .REGS(REGS), .DATA_W(DATA_W)) dut_i (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueKind(issueKind), .issueDest(issueDest),
    .issueReady(issueReady), .issueTag(issueTag),
    .cmplValid(cmplValid), .cmplTag(cmplTag), .cmplValue(cmplValue),
    .cmplMispredict(cmplMispredict),
    .commitRegValid(commitRegValid), .commitRegIdx(commitRegIdx),
    .commitRegValue(commitRegValue),
    .commitStoreValid(commitStoreValid), .commitStoreAddr(commitStoreAddr),
    .commitStoreValue(commitStoreValue),
    .flushOut(flushOut),
    .lookupReg(lookupReg), .lookupHit(lookupHit), .lookupTag(lookupTag),
    .lookupReady(lookupReady), .lookupValue(lookupValue)
  );

  int nTests = 0;
  int nFails = 0;
  int expTail = 0;

  // retirement log filled by the monitor
  logic [1:0]  logKind [32];
  logic [4:0]  logIdx  [32];
  logic [31:0] logVal  [32];
  int          logCount = 0;
  logic        flushSeen = 1'b0;

  always @(negedge clk) begin
    #1;
    if (rstN === 1'b1) begin
      if (commitRegValid && logCount < 32) begin
        logKind[logCount] = 2'd0;
        logIdx[logCount]  = commitRegIdx;
        logVal[logCount]  = commitRegValue;
        logCount++;
      end
      if (commitStoreValid && logCount < 32) begin
        logKind[logCount] = 2'd1;
        logIdx[logCount]  = commitStoreAddr;
        logVal[logCount]  = commitStoreValue;
        logCount++;
      end
      if (flushOut) flushSeen = 1'b1;
    end
  end

  task automatic check(input string what, input logic [63:0] act, input logic [63:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic clearIn();
    issueValid = 1'b0; issueKind = 2'd0; issueDest = 5'd0;
    cmplValid = 1'b0; cmplTag = 3'd0; cmplValue = 32'd0; cmplMispredict = 1'b0;
  endtask

  task automatic issueOp(input logic [1:0] k, input logic [4:0] d,
                         output logic rdy, output logic [2:0] tag, output logic fl);
    @(negedge clk);
    issueValid = 1'b1; issueKind = k; issueDest = d;
    #1;
    rdy = issueReady; tag = issueTag; fl = flushOut;
    @(posedge clk); #1;
    clearIn();
  endtask

  task automatic completeOp(input logic [2:0] t, input logic [31:0] v, input logic m);
    @(negedge clk);
    cmplValid = 1'b1; cmplTag = t; cmplValue = v; cmplMispredict = m;
    @(posedge clk); #1;
    clearIn();
  endtask

  task automatic idleCycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic probe(input logic [4:0] r, output logic hit, output logic [2:0] tag,
                       output logic rdy, output logic [31:0] val);
    @(negedge clk);
    lookupReg = r;
    #1;
    hit = lookupHit; tag = lookupTag; rdy = lookupReady; val = lookupValue;
  endtask

  logic        rdy, fl, hit, lrdy;
  logic [2:0]  tag, ltag;
  logic [31:0] lval;
  logic [2:0]  rowTag [3];
  logic [2:0]  fullTag [8];
  logic [2:0]  tH, tA, tB, tBr, t1, t2;

  initial begin
    #(200000 * 5);
    nTests++; nFails++;
    $display("FAIL watchdog (all requirements): actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    rstN = 1'b0; lookupReg = 5'd0;
    clearIn();
    repeat (3) @(posedge clk);
    #1; rstN = 1'b1;
    #1;
    // R1 reset state
    check("R1 issueReady", issueReady, 1);
    check("R1 commitRegValid", commitRegValid, 0);
    check("R1 commitStoreValid", commitStoreValid, 0);
    check("R1 flushOut", flushOut, 0);
    check("R1 lookupHit", lookupHit, 0);

    // vector table: three instructions, completion order, program-order retirement
    for (int v = 0; v < 6; v++) begin
      int e;
      logCount = 0; flushSeen = 1'b0;
      for (int i = 0; i < 3; i++) begin
        issueOp(VECS[v].kinds[i], VECS[v].dests[i], rdy, tag, fl);
        check("R2 issue tag in vector", tag, expTail);
        rowTag[i] = tag;
        expTail = (expTail + 1) % DEPTH;
      end
      for (int j = 0; j < 3; j++) begin
        int idx;
        idx = int'(VECS[v].order[j]);
        completeOp(rowTag[idx], VECS[v].base + 32'(idx), 1'b0);
      end
      idleCycles(6);
      e = 0;
      for (int i = 0; i < 3; i++) begin
        if (VECS[v].kinds[i] == 2'd0 || VECS[v].kinds[i] == 2'd1) begin
          check("R5 retired port kind", logKind[e], VECS[v].kinds[i]);
          check("R4 retired destination order", logIdx[e], VECS[v].dests[i]);
          check("R4 retired value order", logVal[e], VECS[v].base + 32'(i));
          e++;
        end
      end
      check("R7 retire count per vector", logCount, e);
      check("R7 no flush on good branch", flushSeen, 0);
      for (int i = 0; i < 3; i++) begin
        if (VECS[v].kinds[i] == 2'd0) begin
          probe(VECS[v].dests[i], hit, ltag, lrdy, lval);
          check("R9 mapping dropped after drain", hit, 0);
        end
      end
    end

    // R10 stray completion to an unallocated slot
    logCount = 0;
    completeOp(3'(expTail), 32'hDEAD, 1'b0);
    issueOp(2'd0, 5'd15, rdy, tag, fl);
    check("R2 tag after stray", tag, expTail);
    expTail = (expTail + 1) % DEPTH;
    idleCycles(4);
    check("R10 stray completion ignored", logCount, 0);
    completeOp(tag, 32'h1234, 1'b0);
    idleCycles(3);
    check("R10 real completion retires", logCount, 1);
    check("R10 real value", logVal[0], 32'h1234);

    // R8 / R9 operand lookup and remapping
    logCount = 0;
    issueOp(2'd0, 5'd21, rdy, tH, fl); expTail = (expTail + 1) % DEPTH;
    issueOp(2'd0, 5'd20, rdy, tA, fl); expTail = (expTail + 1) % DEPTH;
    probe(5'd20, hit, ltag, lrdy, lval);
    check("R8 pending hit", hit, 1);
    check("R8 pending tag", ltag, tA);
    check("R8 pending not ready", lrdy, 0);
    completeOp(tA, 32'hAAAA, 1'b0);
    probe(5'd20, hit, ltag, lrdy, lval);
    check("R8 finished ready", lrdy, 1);
    check("R8 finished value", lval, 32'hAAAA);
    check("R4 blocked behind unfinished head", logCount, 0);
    issueOp(2'd0, 5'd20, rdy, tB, fl); expTail = (expTail + 1) % DEPTH;
    probe(5'd20, hit, ltag, lrdy, lval);
    check("R8 youngest writer tag", ltag, tB);
    check("R8 youngest not ready", lrdy, 0);
    completeOp(tH, 32'h2121, 1'b0);
    idleCycles(3);
    check("R4 two retired", logCount, 2);
    check("R4 first retired reg", logIdx[0], 21);
    check("R4 second retired reg", logIdx[1], 20);
    check("R4 second retired value", logVal[1], 32'hAAAA);
    probe(5'd20, hit, ltag, lrdy, lval);
    check("R9 younger mapping kept", hit, 1);
    check("R9 younger mapping tag", ltag, tB);
    probe(5'd21, hit, ltag, lrdy, lval);
    check("R9 own mapping dropped", hit, 0);
    completeOp(tB, 32'hBBBB, 1'b0);
    idleCycles(3);
    probe(5'd20, hit, ltag, lrdy, lval);
    check("R9 last mapping dropped", hit, 0);

    // R3 full buffer and R2 wrap
    logCount = 0;
    for (int i = 0; i < 8; i++) begin
      issueOp(2'd0, 5'(i + 1), rdy, tag, fl);
      check("R3 ready while filling", rdy, 1);
      check("R2 tag while filling", tag, expTail);
      fullTag[i] = tag;
      expTail = (expTail + 1) % DEPTH;
    end
    issueOp(2'd0, 5'd30, rdy, tag, fl);
    check("R3 not ready when full", rdy, 0);
    for (int i = 7; i >= 0; i--) completeOp(fullTag[i], 32'd100 + 32'(i), 1'b0);
    idleCycles(12);
    check("R3 extra issue not allocated", logCount, 8);
    for (int i = 0; i < 8; i++) check("R4 order after fill", logIdx[i], i + 1);
    issueOp(2'd3, 5'd0, rdy, tag, fl);
    check("R2 tag wraps", tag, expTail);
    expTail = (expTail + 1) % DEPTH;
    completeOp(tag, 32'd0, 1'b0);
    idleCycles(3);

    // R6 mispredicted branch flush
    logCount = 0; flushSeen = 1'b0;
    issueOp(2'd2, 5'd0, rdy, tBr, fl);
    issueOp(2'd0, 5'd22, rdy, t1, fl);
    issueOp(2'd1, 5'd5, rdy, t2, fl);
    completeOp(t1, 32'h2222, 1'b0);
    completeOp(t2, 32'h5555, 1'b0);
    probe(5'd22, hit, ltag, lrdy, lval);
    check("R8 hit before flush", hit, 1);
    completeOp(tBr, 32'd0, 1'b1);
    issueOp(2'd0, 5'd23, rdy, tag, fl);
    check("R6 flushOut at retirement", fl, 1);
    check("R6 issueReady low during flush", rdy, 0);
    idleCycles(4);
    check("R6 younger work discarded", logCount, 0);
    probe(5'd22, hit, ltag, lrdy, lval);
    check("R6 mapping cleared", hit, 0);
    probe(5'd23, hit, ltag, lrdy, lval);
    check("R6 issue during flush ignored", hit, 0);
    expTail = 0;
    issueOp(2'd0, 5'd24, rdy, tag, fl);
    check("R6 ready after flush", rdy, 1);
    check("R6 tag restarts at zero", tag, 0);
    completeOp(tag, 32'h2424, 1'b0);
    idleCycles(3);
    check("R6 retires after flush", logCount, 1);
    check("R5 reg value after flush", logVal[0], 32'h2424);

    $display("  [TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

endmodule